// File: doc/BRIEF.md
# E1 System-Side Highway Conditioner

This block sits between an E1 framer core and a serial system highway. The frame has 32 slots of 8 bits each, which gives 256 bit times per frame. A local bit counter and a frame-parity flag track the frame. An external sync pulse realigns both. The sync pulse is sampled on the rising or falling clock edge, and its active level is set by configuration.

Toward the system, the block registers the core's serial stream. On the way it can make two changes:

- On an alarm, it forces the whole frame to all ones (AIS). The alarm request is taken only at frame boundaries.
- It can send the NOTFAS word in slot 0 of the FAS frame as well, so the NOTFAS word appears twice.

While the highway is switched off, the system output enable is held low. Toward the line, the data from the system is then replaced by a programmable idle byte. The highway stays off until the block's internal reset sequence has finished. That sequence is shown by a status output.

Top module: `e1_hwy_cond`

## Requirements
- R1: While `rst_n` is low, `rst_done` and `sys_doe` are 0. `rst_done` becomes 1 after exactly RST_CYCLES rising clock edges following reset release, and then stays 1.
- R2: The bit index counts from 0 to 255 and wraps to 0. A detected sync pulse forces the next bit index to 0 from any position. The frame parity toggles at every frame start: the first frame after reset is even (FAS), the next is odd (NOTFAS), and so on.
- R3: With `cfg_fs_rise`=1 the sync input is sampled on the rising edge that ends the cycle. With `cfg_fs_rise`=0 it is sampled on the falling edge inside the cycle. In both cases the bit after that edge is bit 0.
- R4: With `cfg_fs_high`=1 the sync input is active high. With `cfg_fs_high`=0 it is active low.
- R5: With no AIS and the dual-NOTFAS mode off, `sys_dout` equals `core_bit`, one clock later.
- R6: With `cfg_dual_nf`=1, bits 0..7 of each even frame are replaced by the slot-0 byte captured from the latest odd frame, MSB first, so bit 0 carries the MSB. That stored byte resets to 0xFF.
- R7: With `cfg_ais_lof_en`=1 and `lof_alarm` high at a frame start, every bit of the following frame on `sys_dout` is 1. AIS overrides both the pass-through data and the NOTFAS substitution.
- R8: `mf_tmr_exp` causes AIS only when both `cfg_ais_tmr_en` and `cfg_e1_mode` are 1.
- R9: The alarm request is taken only in the last cycle before a frame start. AIS therefore begins and ends on whole-frame boundaries.
- R10: While the highway is off, `sys_doe` is 0 and `line_dout` carries the idle byte MSB first in every slot: bit i of the frame carries idle bit (7 - i mod 8). While the highway is on, `sys_doe` is 1 and `line_dout` equals `sys_din`, one clock later.
- R11: The idle byte resets to 0xFF. A pulse on `idle_wr` loads it from `idle_code`, and the new value applies from the next clock.
- R12: The highway counts as on only when `cfg_hwy_en` and `rst_done` are both 1. Before `rst_done` is 1, the block behaves as if the highway were off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_in | input | 1 | Frame sync pulse |
| cfg_fs_rise | input | 1 | 1: sample sync on the rising edge; 0: on the falling edge |
| cfg_fs_high | input | 1 | 1: sync active high; 0: sync active low |
| cfg_hwy_en | input | 1 | Highway enable |
| cfg_dual_nf | input | 1 | Send NOTFAS in slot 0 of both frames |
| cfg_ais_lof_en | input | 1 | AIS on loss of frame alignment |
| cfg_ais_tmr_en | input | 1 | AIS on multiframe timer expiry |
| cfg_e1_mode | input | 1 | E1 operation (qualifies timer AIS) |
| idle_code | input | 8 | Idle byte to load |
| idle_wr | input | 1 | Load strobe for the idle byte |
| lof_alarm | input | 1 | Loss of frame alignment level |
| mf_tmr_exp | input | 1 | Multiframe alignment timer expired level |
| core_bit | input | 1 | Serial data from the framer core |
| sys_dout | output | 1 | Serial data toward the system |
| sys_doe | output | 1 | Drive enable for `sys_dout` (0 = high impedance) |
| sys_din | input | 1 | Serial data from the system |
| line_dout | output | 1 | Serial data toward the framer line side |
| rst_done | output | 1 | Internal reset sequence complete |

## Verification
The assertions assume that the sync input is already synchronous to `clk` and is stable around both clock edges. They also assume that the configuration and alarm inputs change only between edges. The stimulus changes every input a short time after a rising edge. For the falling-edge sampling test only, the sync line is changed a second time after the falling edge. This creates pulses that only one of the two edges can see. Edge select and polarity are changed only while the sync line is inactive, so a configuration change can never look like a sync pulse.

// File: rtl/e1hc_pkg.sv
package e1hc_pkg;
  localparam int SLOT_BITS  = 8;
  localparam int SLOTS      = 32;
  localparam int FRAME_BITS = SLOTS * SLOT_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int POS_W      = $clog2(SLOT_BITS);

  typedef struct packed {
    logic [CNT_W-1:0] bit_idx;     // current bit within frame
    logic             odd;         // 1 = NOTFAS frame
    logic             frame_start; // next cycle is bit 0
  } ftime_t;

  // serial order: position 0 carries the most significant bit
  function automatic logic byte_bit(input logic [SLOT_BITS-1:0] b,
                                    input logic [POS_W-1:0] pos);
    return b[(SLOT_BITS-1) - int'(pos)];
  endfunction

  function automatic logic ais_request(input logic lof, input logic lof_en,
                                       input logic tmr, input logic tmr_en,
                                       input logic e1);
    return (lof & lof_en) | (tmr & tmr_en & e1);
  endfunction
endpackage

// File: rtl/e1hc_frame_timer.sv
module e1hc_frame_timer
  import e1hc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fs_pin,
  input  logic   fs_rise,
  input  logic   fs_pol_high,
  output ftime_t tm,
  output logic   fs_hit
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic             fs_act;
  logic             fs_neg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             odd_q;
  logic             at_last;
  logic             frame_start;

  assign fs_act = fs_pin ~^ fs_pol_high;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fs_neg_q <= 1'b0;
    else        fs_neg_q <= fs_act;
  end

  assign fs_hit      = fs_rise ? fs_act : fs_neg_q;
  assign at_last     = (cnt_q == LAST);
  assign frame_start = fs_hit | at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LAST;
      odd_q <= 1'b1;
    end else begin
      cnt_q <= frame_start ? '0 : cnt_q + 1'b1;
      odd_q <= odd_q ^ frame_start;
    end
  end

  assign tm.bit_idx     = cnt_q;
  assign tm.odd         = odd_q;
  assign tm.frame_start = frame_start;

  AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fs_hit |=> (tm.bit_idx == '0)); // R2
  AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (tm.odd != $past(tm.odd))); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (tm.bit_idx == CNT_W'($past(tm.bit_idx) + 1'b1))); // R2
endmodule

// File: rtl/e1hc_sys_path.sv
module e1hc_sys_path
  import e1hc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ftime_t tm,
  input  logic   core_bit,
  input  logic   dual_nf,
  input  logic   hwy_on,
  input  logic   ais_req,
  output logic   sys_dout,
  output logic   sys_doe,
  output logic   ais_active
);
  logic [SLOT_BITS-1:0] nf_q;
  logic                 ais_q;
  logic                 dout_q;
  logic                 doe_q;
  logic [POS_W-1:0]     pos;
  logic                 in_ts0;
  logic                 do_sub;
  logic                 next_bit;

  assign pos    = tm.bit_idx[POS_W-1:0];
  assign in_ts0 = (tm.bit_idx < CNT_W'(SLOT_BITS));
  assign do_sub = dual_nf & ~tm.odd & in_ts0;

  always_comb begin
    if (ais_q)       next_bit = 1'b1;
    else if (do_sub) next_bit = byte_bit(nf_q, pos);
    else             next_bit = core_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nf_q   <= '1;
      ais_q  <= 1'b0;
      dout_q <= 1'b0;
      doe_q  <= 1'b0;
    end else begin
      if (tm.odd && in_ts0)
        nf_q[(SLOT_BITS-1) - int'(pos)] <= core_bit;
      if (tm.frame_start)
        ais_q <= ais_req;
      dout_q <= next_bit;
      doe_q  <= hwy_on;
    end
  end

  assign sys_dout   = dout_q;
  assign sys_doe    = doe_q;
  assign ais_active = ais_q;

  AST_AIS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ais_q |=> sys_dout); // R7
  AST_AIS_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    !tm.frame_start |=> $stable(ais_active)); // R9
  AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!ais_q && !dual_nf) |=> (sys_dout == $past(core_bit))); // R5
  AST_HIZ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !hwy_on |=> !sys_doe); // R10
endmodule

// File: rtl/e1hc_line_path.sv
module e1hc_line_path
  import e1hc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [POS_W-1:0]     pos,
  input  logic                 sys_din,
  input  logic                 hwy_on,
  input  logic [SLOT_BITS-1:0] idle_code,
  input  logic                 idle_wr,
  output logic                 line_dout
);
  logic [SLOT_BITS-1:0] idle_q;
  logic                 dout_q;
  logic                 idle_bit;

  assign idle_bit = byte_bit(idle_q, pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '1;
      dout_q <= 1'b1;
    end else begin
      if (idle_wr) idle_q <= idle_code;
      dout_q <= hwy_on ? sys_din : idle_bit;
    end
  end

  assign line_dout = dout_q;

  AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    !hwy_on |=> (line_dout == $past(idle_bit))); // R10
  AST_LINE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    hwy_on |=> (line_dout == $past(sys_din))); // R10
endmodule

// File: rtl/e1hc_rst_seq.sv
module e1hc_rst_seq #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_done
);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam logic [RW-1:0] LAST = RW'(RST_CYCLES - 1);

  logic [RW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q  <= cnt_q + 1'b1;
      done_q <= (cnt_q == LAST);
    end
  end

  assign rst_done = done_q;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |=> rst_done); // R1
endmodule

// File: rtl/e1_hwy_cond.sv
module e1_hwy_cond
  import e1hc_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs_in,
  input  logic       cfg_fs_rise,
  input  logic       cfg_fs_high,
  input  logic       cfg_hwy_en,
  input  logic       cfg_dual_nf,
  input  logic       cfg_ais_lof_en,
  input  logic       cfg_ais_tmr_en,
  input  logic       cfg_e1_mode,
  input  logic [7:0] idle_code,
  input  logic       idle_wr,
  input  logic       lof_alarm,
  input  logic       mf_tmr_exp,
  input  logic       core_bit,
  output logic       sys_dout,
  output logic       sys_doe,
  input  logic       sys_din,
  output logic       line_dout,
  output logic       rst_done
);
  ftime_t tm;
  logic   fs_hit;
  logic   hwy_on;
  logic   ais_req;
  logic   ais_active;

  e1hc_rst_seq #(.RST_CYCLES(RST_CYCLES)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_done(rst_done)
  );

  e1hc_frame_timer timer_i (
    .clk(clk), .rst_n(rst_n), .fs_pin(fs_in), .fs_rise(cfg_fs_rise),
    .fs_pol_high(cfg_fs_high), .tm(tm), .fs_hit(fs_hit)
  );

  assign hwy_on  = cfg_hwy_en & rst_done;
  assign ais_req = ais_request(lof_alarm, cfg_ais_lof_en, mf_tmr_exp,
                               cfg_ais_tmr_en, cfg_e1_mode);

  e1hc_sys_path sys_i (
    .clk(clk), .rst_n(rst_n), .tm(tm), .core_bit(core_bit),
    .dual_nf(cfg_dual_nf), .hwy_on(hwy_on), .ais_req(ais_req),
    .sys_dout(sys_dout), .sys_doe(sys_doe), .ais_active(ais_active)
  );

  e1hc_line_path line_i (
    .clk(clk), .rst_n(rst_n), .pos(tm.bit_idx[POS_W-1:0]), .sys_din(sys_din),
    .hwy_on(hwy_on), .idle_code(idle_code), .idle_wr(idle_wr),
    .line_dout(line_dout)
  );

  AST_GATE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_done |-> !sys_doe); // R12
  AST_TMR_E1_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (tm.frame_start && !cfg_e1_mode && !(lof_alarm && cfg_ais_lof_en)) |=> !ais_active); // R8
  AST_SYNC_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_hit && tm.bit_idx != '1) |=> tm.odd != $past(tm.odd)); // R3
endmodule

// File: tb/e1_hwy_cond_tb_top.sv
module e1_hwy_cond_tb_top;
  localparam int RST = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic fs_act = 1'b0;
  logic fs_in;
  logic cfg_fs_rise = 1'b1, cfg_fs_high = 1'b1, cfg_hwy_en = 1'b1;
  logic cfg_dual_nf = 1'b0, cfg_ais_lof_en = 1'b0, cfg_ais_tmr_en = 1'b0;
  logic cfg_e1_mode = 1'b0;
  logic [7:0] idle_code = 8'h00;
  logic idle_wr = 1'b0, lof_alarm = 1'b0, mf_tmr_exp = 1'b0;
  logic core_bit = 1'b0, sys_din = 1'b0;
  logic sys_dout, sys_doe, line_dout, rst_done;

  assign fs_in = cfg_fs_high ? fs_act : ~fs_act;

  e1_hwy_cond #(.RST_CYCLES(RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .fs_in(fs_in), .cfg_fs_rise(cfg_fs_rise),
    .cfg_fs_high(cfg_fs_high), .cfg_hwy_en(cfg_hwy_en), .cfg_dual_nf(cfg_dual_nf),
    .cfg_ais_lof_en(cfg_ais_lof_en), .cfg_ais_tmr_en(cfg_ais_tmr_en),
    .cfg_e1_mode(cfg_e1_mode), .idle_code(idle_code), .idle_wr(idle_wr),
    .lof_alarm(lof_alarm), .mf_tmr_exp(mf_tmr_exp), .core_bit(core_bit),
    .sys_dout(sys_dout), .sys_doe(sys_doe), .sys_din(sys_din),
    .line_dout(line_dout), .rst_done(rst_done)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  // bench model of the frame
  int m = 255;
  bit par = 1'b1, ais_m = 1'b0, done_m = 1'b0;
  bit fs_e = 1'b0, fs_l = 1'b0;
  logic [7:0] nf_m = 8'hFF, idle_m = 8'hFF;
  int k = 0;
  string tag = "R12";
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b bit=%0d t=%0t", req, act, exp, m, $time);
    end
  endtask

  task automatic tick(input int sync_at, input bit early, input bit late);
    bit hit, eff, exp_sys;
    @(posedge clk); #2;
    eff = cfg_hwy_en && done_m;
    if (ais_m) exp_sys = 1'b1;
    else if (cfg_dual_nf && !par && m < 8) exp_sys = nf_m[7-m];
    else exp_sys = core_bit;
    chk(tag, sys_dout, exp_sys);
    chk(tag, sys_doe, eff);
    chk(tag, line_dout, eff ? sys_din : idle_m[7-(m%8)]);
    chk("R1", rst_done, (k + 1) >= RST);
    // advance model across the edge just taken
    hit = cfg_fs_rise ? fs_l : fs_e;
    if (par && m < 8) nf_m[7-m] = core_bit;
    if (hit || m == 255) begin
      ais_m = (lof_alarm && cfg_ais_lof_en) || (mf_tmr_exp && cfg_ais_tmr_en && cfg_e1_mode);
      par = !par;
    end
    m = hit ? 0 : (m + 1) % 256;
    k++;
    done_m = (k >= RST);
    if (idle_wr) idle_m = idle_code;
    // drive the next cycle
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    core_bit = lfsr[0];
    sys_din  = lfsr[7];
    idle_wr  = 1'b0;
    if (m == sync_at) begin early = 1'b1; late = 1'b1; end
    fs_e = early; fs_l = late;
    fs_act = early;
    #10;
    fs_act = late;
  endtask

  task automatic run(input int n, input int sync_at, input string t);
    tag = t;
    for (int i = 0; i < n; i++) tick(sync_at, 1'b0, 1'b0);
  endtask

  initial begin
    #45;
    chk("R1", rst_done, 1'b0);
    chk("R1", sys_doe, 1'b0);
    @(posedge clk); #2; rst_n = 1'b1;
    run(40, 255, "R12");
    run(560, 255, "R5");
    // highway off, idle byte programming
    cfg_hwy_en = 1'b0;
    run(300, 255, "R10");
    idle_code = 8'hA5; idle_wr = 1'b1;
    run(300, 255, "R11");
    idle_code = 8'h3C; idle_wr = 1'b1;
    run(300, 255, "R11");
    cfg_hwy_en = 1'b1;
    // dual NOTFAS
    cfg_dual_nf = 1'b1;
    run(800, 255, "R6");
    cfg_dual_nf = 1'b0;
    // falling-edge sampling
    cfg_fs_rise = 1'b0;
    run(520, 255, "R3");
    run(37, -1, "R3");
    tag = "R3"; tick(-1, 1'b1, 1'b0); // visible only to falling edge
    run(300, 255, "R3");
    cfg_fs_rise = 1'b1;
    run(50, 255, "R3");
    tick(-1, 1'b1, 1'b0); // hidden from rising edge
    run(60, -1, "R3");
    tick(-1, 1'b0, 1'b1); // seen by rising edge
    run(300, 255, "R3");
    // active-low sync, both edges
    cfg_fs_high = 1'b0;
    run(520, 255, "R4");
    cfg_fs_rise = 1'b0;
    run(520, 255, "R4");
    cfg_fs_rise = 1'b1;
    cfg_fs_high = 1'b1;
    // resync mid frame
    run(100, -1, "R2");
    tag = "R2"; tick(-1, 1'b1, 1'b1);
    run(600, 255, "R2");
    // AIS on loss of alignment, with dual mode to check priority
    cfg_ais_lof_en = 1'b1; cfg_dual_nf = 1'b1;
    run(90, 255, "R7");
    lof_alarm = 1'b1;
    run(600, 255, "R7");
    lof_alarm = 1'b0;
    run(400, 255, "R9");
    cfg_ais_lof_en = 1'b0; cfg_dual_nf = 1'b0;
    // timer AIS qualified by E1 mode
    cfg_ais_tmr_en = 1'b1; mf_tmr_exp = 1'b1; cfg_e1_mode = 1'b0;
    run(500, 255, "R8");
    cfg_e1_mode = 1'b1;
    run(500, 255, "R8");
    mf_tmr_exp = 1'b0;
    run(400, 255, "R9");
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule